// File: doc/BRIEF.md
# Sticky Link-Status Register Bank

This block holds a small bank of read-only status words that record link fault conditions. Each bit of each word is one of three kinds, chosen per bit by two parameter masks. A latch-high bit rests at 0 and sticks at 1 once its fault is seen. A latch-low bit rests at 1 and sticks at 0 once its fault is seen. A live bit follows its condition input with no memory. Condition inputs are active-high fault flags for every bit kind.

Software reads a word through a simple access port: a strobe, a write flag and a byte address. A read returns the word as it stood before the access, and then puts every sticky bit of that word back to its resting value. A fault that is still present at the read sets the bit again in the same edge. The next read then shows the fault again, so an ongoing fault can be told apart from one that has already cleared. Writes, reads of unmapped addresses and misaligned reads change nothing and return zero.

Top module: `lcr_status_bank`

## Requirements
- R1: After reset every latch-high bit is 0, every latch-low bit is 1 and `rd_data_o` is 0. With the default masks an idle word reads 0x0000FF00.
- R2: A latch-high bit becomes 1 on the first clock edge at which its condition is 1, and stays 1 until its word is read. With the default masks these are bits 0 to 7.
- R3: A latch-low bit becomes 0 on the first clock edge at which its condition is 1, and stays 0 until its word is read. With the default masks these are bits 8 to 15.
- R4: A read returns the word's content from before the access edge. It then returns every sticky bit of that word to its resting value, so a second read with no new fault returns the resting value.
- R5: If a sticky bit's condition is 1 at the edge of a read of its word, the latched value wins over the clear. A fault held across reads is reported by every read. A fault that is present only in the read cycle is missing from that read's data and appears in the next read.
- R6: Live bits, which are bits 16 to 31 with the default masks, return the condition level present at the read edge, with no latching.
- R7: Word i sits at byte address BASE_ADDR + 4*i. With the defaults, words 0 to 9 sit at 0x200 to 0x224. Read data appears on `rd_data_o` in the cycle after the access and is 0 in every cycle after which no mapped read took place.
- R8: A read clears only the word it addresses. All other words keep their latched bits.
- R9: An access with `acc_we_i` = 1 clears nothing and is followed by `rd_data_o` = 0.
- R10: A read of an address outside the mapped words (for example 0x228 to 0x2AF or below 0x200), or of an address with nonzero bits [1:0], returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_en_i | input | 1 | Access strobe, one cycle per access |
| acc_we_i | input | 1 | Access is a write (ignored by the bank) |
| acc_addr_i | input | ADDR_W (12) | Byte address of the access |
| cond_i | input | NUM_REGS*DATA_W (320) | Fault condition flags; bit DATA_W*i+b belongs to bit b of word i |
| rd_data_o | output | DATA_W (32) | Registered read data |

## Verification
A condition pulse is latched at the edge it spans, so it can be seen at the earliest by a read whose access edge comes one cycle later. Read data is registered, so each read is checked at the falling edge that follows its access edge, which is exactly one cycle after the strobe. The clearing effect of a read is checked by a second read at least one cycle later. The bench drives strobes and condition flags on falling edges, so every rising edge sees settled inputs. The case where a fault and a read meet in the same cycle is checked by raising both at the same falling edge. The bench expects the old value back from that read and the fault in the next one.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

   typedef enum logic [1:0] {
      CELL_LIVE       = 2'd0,
      CELL_LATCH_HIGH = 2'd1,
      CELL_LATCH_LOW  = 2'd2
   } cell_kind_e;

   function automatic cell_kind_e cell_kind(input logic sticky, input logic latch_high);
      if (!sticky)
         return CELL_LIVE;
      else if (latch_high)
         return CELL_LATCH_HIGH;
      else
         return CELL_LATCH_LOW;
   endfunction

endpackage

// File: rtl/lcr_addr_decode.sv
module lcr_addr_decode #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_REGS  = 10,
   parameter int unsigned BASE_ADDR = 'h200,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              acc_en_i,
   input  logic              acc_we_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   output logic              rd_hit_o,
   output logic [IDX_W-1:0]  rd_index_o,
   output logic [NUM_REGS-1:0] clr_o
);

   localparam int unsigned   WORD_W  = ADDR_W - 2;
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
   localparam logic [WORD_W-1:0] BASE_WORD = BASE_V[ADDR_W-1:2];
   localparam logic [WORD_W-1:0] NUM_WORD  = WORD_W'(NUM_REGS);

   logic [WORD_W-1:0] word_addr;
   logic [WORD_W-1:0] word_off;
   logic              aligned;
   logic              above_base;
   logic              in_span;

   assign word_addr  = acc_addr_i[ADDR_W-1:2];
   assign word_off   = word_addr - BASE_WORD;
   assign aligned    = (acc_addr_i[1:0] == 2'b00);
   assign above_base = (word_addr >= BASE_WORD);
   assign in_span    = (word_off < NUM_WORD);

   assign rd_hit_o   = acc_en_i && !acc_we_i && aligned && above_base && in_span;
   assign rd_index_o = word_off[IDX_W-1:0];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_clr
      assign clr_o[i] = rd_hit_o && (word_off == WORD_W'(i));
   end

   AST_ONE_WORD_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(clr_o)); // R8

   AST_WRITE_CLEARS_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_en_i && acc_we_i) |-> (clr_o == '0)); // R9

   AST_MISALIGNED_CLEARS_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_addr_i[1:0] != 2'b00) |-> (clr_o == '0)); // R10

endmodule

// File: rtl/lcr_status_word.sv
module lcr_status_word
   import lcr_pkg::*;
#(
   parameter int unsigned        DATA_W      = 32,
   parameter logic [DATA_W-1:0]  STICKY_MASK = '0,
   parameter logic [DATA_W-1:0]  HIGH_MASK   = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] cond_i,
   input  logic              clr_i,
   output logic [DATA_W-1:0] word_o
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam cell_kind_e KIND = cell_kind(STICKY_MASK[b], HIGH_MASK[b]);

      if (KIND == CELL_LATCH_HIGH) begin : g_lh
         logic q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)
               q <= 1'b0;
            else if (clr_i)
               q <= cond_i[b];
            else
               q <= q | cond_i[b];
         end
         assign word_o[b] = q;

         AST_LH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cond_i[b] |=> word_o[b]); // R2
         AST_LH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (word_o[b] && !clr_i) |=> word_o[b]); // R2
         AST_LH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i && !cond_i[b]) |=> !word_o[b]); // R4
      end else if (KIND == CELL_LATCH_LOW) begin : g_ll
         logic q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)
               q <= 1'b1;
            else if (clr_i)
               q <= ~cond_i[b];
            else
               q <= q & ~cond_i[b];
         end
         assign word_o[b] = q;

         AST_LL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cond_i[b] |=> !word_o[b]); // R3
         AST_LL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!word_o[b] && !clr_i) |=> !word_o[b]); // R3
         AST_LL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i && !cond_i[b]) |=> word_o[b]); // R4
      end else begin : g_live
         assign word_o[b] = cond_i[b];
      end
   end

endmodule

// File: rtl/lcr_read_mux.sv
module lcr_read_mux #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 10,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [NUM_REGS*DATA_W-1:0] words_i,
   input  logic                       rd_hit_i,
   input  logic [IDX_W-1:0]           rd_index_i,
   output logic [DATA_W-1:0]          rd_data_o
);

   logic [DATA_W-1:0] sel_word;

   always_comb begin
      sel_word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_index_i == IDX_W'(i))
            sel_word = words_i[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         rd_data_o <= '0;
      else if (rd_hit_i)
         rd_data_o <= sel_word;
      else
         rd_data_o <= '0;
   end

   AST_IDLE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_hit_i |=> (rd_data_o == '0)); // R7

endmodule

// File: rtl/lcr_status_bank.sv
module lcr_status_bank #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_REGS  = 10,
   parameter int unsigned BASE_ADDR = 'h200,
   parameter logic [NUM_REGS*DATA_W-1:0] STICKY_MASK =
      {NUM_REGS{{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}}},
   parameter logic [NUM_REGS*DATA_W-1:0] HIGH_MASK =
      {NUM_REGS{{(DATA_W-DATA_W/4){1'b0}}, {(DATA_W/4){1'b1}}}}
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       acc_en_i,
   input  logic                       acc_we_i,
   input  logic [ADDR_W-1:0]          acc_addr_i,
   input  logic [NUM_REGS*DATA_W-1:0] cond_i,
   output logic [DATA_W-1:0]          rd_data_o
);

   localparam int unsigned IDX_W    = $clog2(NUM_REGS);
   localparam longint unsigned SPAN = longint'(BASE_ADDR) + 4 * longint'(NUM_REGS);

   if (NUM_REGS < 2) begin : g_chk_regs
      $error("lcr_status_bank: NUM_REGS must be at least 2");
   end
   if (DATA_W < 4) begin : g_chk_width
      $error("lcr_status_bank: DATA_W must be at least 4");
   end
   if (ADDR_W < IDX_W + 2) begin : g_chk_addr
      $error("lcr_status_bank: ADDR_W too narrow for NUM_REGS words");
   end
   if ((BASE_ADDR % 4) != 0) begin : g_chk_align
      $error("lcr_status_bank: BASE_ADDR must be word aligned");
   end
   if (SPAN > (longint'(1) << ADDR_W)) begin : g_chk_span
      $error("lcr_status_bank: register span exceeds address space");
   end

   logic                       rd_hit;
   logic [IDX_W-1:0]           rd_index;
   logic [NUM_REGS-1:0]        clr_vec;
   logic [NUM_REGS*DATA_W-1:0] words;

   lcr_addr_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_REGS  (NUM_REGS),
      .BASE_ADDR (BASE_ADDR)
   ) u_decode (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .acc_en_i   (acc_en_i),
      .acc_we_i   (acc_we_i),
      .acc_addr_i (acc_addr_i),
      .rd_hit_o   (rd_hit),
      .rd_index_o (rd_index),
      .clr_o      (clr_vec)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      lcr_status_word #(
         .DATA_W      (DATA_W),
         .STICKY_MASK (STICKY_MASK[i*DATA_W +: DATA_W]),
         .HIGH_MASK   (HIGH_MASK[i*DATA_W +: DATA_W])
      ) u_word (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .cond_i (cond_i[i*DATA_W +: DATA_W]),
         .clr_i  (clr_vec[i]),
         .word_o (words[i*DATA_W +: DATA_W])
      );
   end

   lcr_read_mux #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_mux (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .words_i    (words),
      .rd_hit_i   (rd_hit),
      .rd_index_i (rd_index),
      .rd_data_o  (rd_data_o)
   );

   AST_WRITE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_en_i && acc_we_i) |=> (rd_data_o == '0)); // R9

   AST_RESERVED_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_en_i && (longint'(acc_addr_i) >= SPAN)) |=> (rd_data_o == '0)); // R10

endmodule

// File: tb/lcr_status_bank_tb.sv
`timescale 1ns/1ps
module lcr_status_bank_tb_top;

   localparam int NREG = 10;
   localparam int DW   = 32;
   localparam logic [31:0] IDLE = 32'h0000_FF00;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic              we = 1'b0;
   logic [11:0]       addr = '0;
   logic [NREG*DW-1:0] cond = '0;
   logic [DW-1:0]     rd_data;

   int n_total = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   lcr_status_bank dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .acc_en_i   (en),
      .acc_we_i   (we),
      .acc_addr_i (addr),
      .cond_i     (cond),
      .rd_data_o  (rd_data)
   );

   function automatic logic [11:0] reg_addr(input int i);
      return 12'(32'h200 + 4 * i);
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_total++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      en = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      d = rd_data;
      en = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      en = 1'b1; we = 1'b1; addr = a;
      @(negedge clk);
      d = rd_data;
      en = 1'b0; we = 1'b0;
   endtask

   task automatic pulse(input int r, input int b);
      @(negedge clk);
      cond[r*DW+b] = 1'b1;
      @(negedge clk);
      cond[r*DW+b] = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 rd_data after reset", rd_data, 32'h0);
      for (int i = 0; i < NREG; i++) begin
         rd(reg_addr(i), d);
         check("R1 idle word", d, IDLE);
      end
   endtask

   task automatic t_latch_high();
      logic [31:0] d;
      pulse(2, 3);
      repeat (3) @(negedge clk);
      rd(reg_addr(2), d);
      check("R2 latch-high held", d, IDLE | 32'h8);
      rd(reg_addr(2), d);
      check("R4 latch-high cleared by read", d, IDLE);
   endtask

   task automatic t_latch_low();
      logic [31:0] d;
      pulse(5, 10);
      rd(reg_addr(5), d);
      check("R3 latch-low held", d, IDLE & ~32'h400);
      rd(reg_addr(5), d);
      check("R4 latch-low cleared by read", d, IDLE);
   endtask

   task automatic t_persistent();
      logic [31:0] d;
      @(negedge clk);
      cond[1*DW+12] = 1'b1;
      cond[0*DW+0]  = 1'b1;
      rd(reg_addr(1), d);
      check("R5 held fault first read", d, IDLE & ~32'h1000);
      rd(reg_addr(1), d);
      check("R5 held fault second read", d, IDLE & ~32'h1000);
      rd(reg_addr(0), d);
      check("R5 held latch-high read", d, IDLE | 32'h1);
      cond[1*DW+12] = 1'b0;
      cond[0*DW+0]  = 1'b0;
      rd(reg_addr(1), d);
      check("R5 relatched after last read", d, IDLE & ~32'h1000);
      rd(reg_addr(1), d);
      check("R5 clears once fault gone", d, IDLE);
      rd(reg_addr(0), d);
      check("R5 latch-high relatched", d, IDLE | 32'h1);
      rd(reg_addr(0), d);
      check("R5 latch-high clears once gone", d, IDLE);
   endtask

   task automatic t_same_cycle();
      logic [31:0] d;
      @(negedge clk);
      cond[8*DW+6] = 1'b1;
      en = 1'b1; we = 1'b0; addr = reg_addr(8);
      @(negedge clk);
      d = rd_data;
      en = 1'b0;
      cond[8*DW+6] = 1'b0;
      check("R5 read-cycle fault not in data", d, IDLE);
      rd(reg_addr(8), d);
      check("R5 latch wins over clear", d, IDLE | 32'h40);
      rd(reg_addr(8), d);
      check("R5 cleared afterwards", d, IDLE);
   endtask

   task automatic t_live();
      logic [31:0] d;
      @(negedge clk);
      cond[7*DW+20] = 1'b1;
      rd(reg_addr(7), d);
      check("R6 live bit high", d, IDLE | 32'h0010_0000);
      cond[7*DW+20] = 1'b0;
      rd(reg_addr(7), d);
      check("R6 live bit follows release", d, IDLE);
   endtask

   task automatic t_map();
      logic [31:0] d;
      @(negedge clk);
      for (int i = 0; i < NREG; i++) cond[i*DW + (i % 8)] = 1'b1;
      @(negedge clk);
      cond = '0;
      @(negedge clk);
      check("R7 no read gives zero", rd_data, 32'h0);
      for (int i = 0; i < NREG; i++) begin
         rd(reg_addr(i), d);
         check("R7 R8 word at base+4i keeps own bit", d, IDLE | (32'h1 << (i % 8)));
      end
      for (int i = 0; i < NREG; i++) begin
         rd(reg_addr(i), d);
         check("R8 each word cleared by own read", d, IDLE);
      end
   endtask

   task automatic t_other_addr();
      logic [31:0] d;
      pulse(4, 1);
      rd(reg_addr(3), d);
      check("R8 neighbour read", d, IDLE);
      rd(reg_addr(5), d);
      check("R8 neighbour read", d, IDLE);
      rd(reg_addr(4), d);
      check("R8 word kept its bit", d, IDLE | 32'h2);
   endtask

   task automatic t_write();
      logic [31:0] d;
      pulse(6, 2);
      wr(reg_addr(6), d);
      check("R9 write returns zero", d, 32'h0);
      rd(reg_addr(6), d);
      check("R9 write did not clear", d, IDLE | 32'h4);
   endtask

   task automatic t_reserved();
      logic [31:0] d;
      pulse(9, 5);
      rd(12'h228, d);
      check("R10 reserved 0x228", d, 32'h0);
      rd(12'h2AC, d);
      check("R10 reserved 0x2AC", d, 32'h0);
      rd(12'h1FC, d);
      check("R10 below base", d, 32'h0);
      rd(12'h226, d);
      check("R10 misaligned", d, 32'h0);
      rd(12'h225, d);
      check("R10 misaligned", d, 32'h0);
      rd(reg_addr(9), d);
      check("R10 word not cleared", d, IDLE | 32'h20);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch_high();
      t_latch_low();
      t_persistent();
      t_same_cycle();
      t_live();
      t_map();
      t_other_addr();
      t_write();
      t_reserved();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!finished) begin
         finished = 1'b1;
         n_total++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

endmodule